// File: doc/BRIEF.md
# Adaptive Impulse-Noise Median Selector

This block sits after a median stage in an impulse-noise filter. For every window it receives the centre sample, the sample to its immediate left and right, and the median already computed for that window. It decides whether the centre sample is an impulse. If it is, the block replaces the centre with the median. If it is not, the centre passes through unchanged, so clean detail is kept.

Each neighbour difference is formed by a subtractor one bit wider than a sample. The sign of that result selects either the raw difference or its inverted-plus-one form, which gives the magnitude. Both magnitudes are compared against a threshold that is set at run time. The window is flagged as noisy only when both magnitudes are strictly above the threshold.

Windows enter and leave on valid/ready streams through one output register. A window is accepted on a rising clock edge when `win_valid` and `win_ready` are both high. The result is presented from that same edge. While `pix_valid` is high and `pix_ready` is low, the output holds steady and `win_ready` stays low, so no new window can overwrite it. The threshold pin is plain control and is sampled when a window is accepted.

Top module: `impulse_median_sel`

## Requirements
- R1: Each neighbour magnitude equals the true absolute difference between that neighbour and the centre over the full sample range (for example 0 against 255 gives 255), with no wrap-around.
- R2: The noise decision is 1 exactly when both the left and the right magnitude are strictly greater than `noise_thr`. Equality, or only one side above the threshold, gives 0.
- R3: When the decision is 1, `pix_data` carries the median of that window and `pix_noise` is 1.
- R4: When the decision is 0, `pix_data` carries the centre sample unchanged and `pix_noise` is 0.
- R5: A window accepted on a rising edge (`win_valid` and `win_ready` both high) is presented on `pix_data`/`pix_noise` with `pix_valid` high right after that same edge.
- R6: `win_ready` is high when the output register is empty or is being drained in that cycle (`pix_ready` high). With `pix_ready` high and no new window, `pix_valid` falls after the next edge.
- R7: While `pix_valid` is high and `pix_ready` is low, `pix_data` and `pix_noise` hold their values, `pix_valid` stays high, and a window offered at that time is not taken.
- R8: After reset is asserted (`rst_n` low), `pix_valid` is 0 and `pix_noise` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_valid | input | 1 | A window is offered |
| win_ready | output | 1 | The block can take a window this cycle |
| win_left | input | W | Left neighbour sample |
| win_centre | input | W | Centre sample |
| win_right | input | W | Right neighbour sample |
| win_median | input | W | Median of the window from the median stage |
| noise_thr | input | W | Threshold for the magnitude comparison |
| pix_valid | output | 1 | Output sample valid |
| pix_ready | input | 1 | Downstream takes the output sample |
| pix_data | output | W | Filtered sample |
| pix_noise | output | 1 | 1 when the centre was judged an impulse |

## Verification
The bound checker checks the stream rules on every cycle. It checks that an accepted window shows up on the next output cycle, that a stalled output holds, and that a drained, empty cycle clears the output valid. It also checks that the output always carries either the median or the centre, as the flag says. Whether the flag itself is right depends on the arithmetic. That part is shown only by the bench's table of windows: full-scale extremes, threshold equality against strict excess, one-sided deviation, and mixed directions. The bench's directed tests cover reset and back-pressure.

// File: rtl/impulse_sel_pkg.sv
package impulse_sel_pkg;
  localparam int SIDE_LEFT  = 0;
  localparam int SIDE_RIGHT = 1;
  localparam int NUM_SIDES  = 2;
endpackage

// File: rtl/nbr_absdiff.sv
module nbr_absdiff #(
  parameter int W = 8
) (
  input  logic [W-1:0] nbr,
  input  logic [W-1:0] centre,
  output logic [W-1:0] mag
);
  localparam int DW = W + 1;

  logic [DW-1:0] diff;
  logic [DW:0]   negated;
  logic          borrow;

  always_comb begin
    diff    = {1'b0, nbr} - {1'b0, centre};
    borrow  = diff[DW-1];
    negated = {1'b0, ~diff} + {{DW{1'b0}}, 1'b1};
    if (borrow)
      mag = negated[W-1:0];
    else
      mag = diff[W-1:0];
  end
endmodule

// File: rtl/impulse_vote.sv
module impulse_vote #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic [N-1:0][W-1:0] mags,
  input  logic [W-1:0]        thr,
  output logic                impulse
);
  logic [N-1:0] above;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign above[g] = (mags[g] > thr);
  end

  assign impulse = &above;
endmodule

// File: rtl/impulse_median_sel.sv
module impulse_median_sel
  import impulse_sel_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         win_valid,
  output logic         win_ready,
  input  logic [W-1:0] win_left,
  input  logic [W-1:0] win_centre,
  input  logic [W-1:0] win_right,
  input  logic [W-1:0] win_median,
  input  logic [W-1:0] noise_thr,
  output logic         pix_valid,
  input  logic         pix_ready,
  output logic [W-1:0] pix_data,
  output logic         pix_noise
);
  logic [NUM_SIDES-1:0][W-1:0] nbrs;
  logic [NUM_SIDES-1:0][W-1:0] mags;
  logic                        impulse;
  logic                        take;
  logic [W-1:0]                chosen;

  assign nbrs[SIDE_LEFT]  = win_left;
  assign nbrs[SIDE_RIGHT] = win_right;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    nbr_absdiff #(.W(W)) u_absdiff (
      .nbr    (nbrs[s]),
      .centre (win_centre),
      .mag    (mags[s])
    );
  end

  impulse_vote #(.W(W), .N(NUM_SIDES)) u_vote (
    .mags    (mags),
    .thr     (noise_thr),
    .impulse (impulse)
  );

  assign win_ready = !pix_valid || pix_ready;
  assign take      = win_valid && win_ready;
  assign chosen    = impulse ? win_median : win_centre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_noise <= 1'b0;
    end else if (take) begin
      pix_valid <= 1'b1;
      pix_data  <= chosen;
      pix_noise <= impulse;
    end else if (pix_ready) begin
      pix_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/impulse_median_sel_chk.sv
module impulse_median_sel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         win_valid,
  input logic         win_ready,
  input logic [W-1:0] win_centre,
  input logic [W-1:0] win_median,
  input logic         pix_valid,
  input logic         pix_ready,
  input logic [W-1:0] pix_data,
  input logic         pix_noise
);
  p_accept_shows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready) |=> pix_valid);

  p_noise_median_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready) |=> (!pix_noise || pix_data == $past(win_median)));

  p_clean_centre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready) |=> (pix_noise || pix_data == $past(win_centre)));

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !win_valid) |=> !pix_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_noise)));

  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |-> !win_ready);
endmodule

bind impulse_median_sel impulse_median_sel_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .win_valid  (win_valid),
  .win_ready  (win_ready),
  .win_centre (win_centre),
  .win_median (win_median),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_data   (pix_data),
  .pix_noise  (pix_noise)
);

// File: tb/test_impulse_median_sel.sv
module test_impulse_median_sel;
  localparam int W = 8;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         win_valid = 1'b0;
  logic         win_ready;
  logic [W-1:0] win_left = '0, win_centre = '0, win_right = '0, win_median = '0, noise_thr = '0;
  logic         pix_valid;
  logic         pix_ready = 1'b1;
  logic [W-1:0] pix_data;
  logic         pix_noise;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  impulse_median_sel #(.W(W)) i_impulse_median_sel (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
    .win_left(win_left), .win_centre(win_centre), .win_right(win_right),
    .win_median(win_median), .noise_thr(noise_thr), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_noise(pix_noise)
  );

  // left, centre, right, median, threshold, expected data, expected flag
  localparam logic [NV-1:0][6*W:0] VECS = {
    {8'd10,  8'd255, 8'd12,  8'd11,  8'd40,  8'd11,  1'b1}, // R1 R3 bright impulse
    {8'd250, 8'd0,   8'd245, 8'd248, 8'd40,  8'd248, 1'b1}, // R1 R3 dark impulse
    {8'd10,  8'd12,  8'd14,  8'd12,  8'd40,  8'd12,  1'b0}, // R4 smooth ramp
    {8'd10,  8'd200, 8'd180, 8'd100, 8'd40,  8'd200, 1'b0}, // R2 one side only
    {8'd0,   8'd255, 8'd0,   8'd0,   8'd254, 8'd0,   1'b1}, // R1 full scale above thr
    {8'd0,   8'd255, 8'd0,   8'd0,   8'd255, 8'd255, 1'b0}, // R2 equal to thr
    {8'd50,  8'd90,  8'd130, 8'd70,  8'd40,  8'd90,  1'b0}, // R2 both equal
    {8'd50,  8'd91,  8'd131, 8'd70,  8'd40,  8'd91,  1'b0}, // R2 one equal one above
    {8'd49,  8'd90,  8'd131, 8'd70,  8'd40,  8'd70,  1'b1}, // R2 both just above
    {8'd255, 8'd0,   8'd255, 8'd255, 8'd0,   8'd255, 1'b1}, // R1 zero thr extremes
    {8'd7,   8'd7,   8'd7,   8'd3,   8'd0,   8'd7,   1'b0}, // R2 zero diffs
    {8'd100, 8'd20,  8'd30,  8'd30,  8'd5,   8'd30,  1'b1}, // R3 both neighbours above
    {8'd200, 8'd150, 8'd100, 8'd150, 8'd30,  8'd150, 1'b1}  // R2 mixed directions
  };

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input logic [6*W:0] v);
    @(negedge clk);
    win_valid  = 1'b1;
    win_left   = v[6*W -: W];
    win_centre = v[5*W -: W];
    win_right  = v[4*W -: W];
    win_median = v[3*W -: W];
    noise_thr  = v[2*W -: W];
  endtask

  initial begin
    #1;
    check("R8 valid in reset", {8'd0, pix_valid}, 9'd0);
    check("R8 flag in reset", {8'd0, pix_noise}, 9'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = NV - 1; i >= 0; i--) begin
      offer(VECS[i]);
      @(posedge clk); #1;
      check("R5 valid after accept", {8'd0, pix_valid}, 9'd1);
      check("R3/R4 data", {1'b0, pix_data}, {1'b0, VECS[i][W:1]});
      check("R2 flag", {8'd0, pix_noise}, {8'd0, VECS[i][0]});
    end

    @(negedge clk);
    win_valid = 1'b0;
    @(posedge clk); #1;
    check("R6 drain clears valid", {8'd0, pix_valid}, 9'd0);

    // back-pressure: load an impulse, stall, offer a clean window
    offer({8'd10, 8'd255, 8'd12, 8'd11, 8'd40, 8'd11, 1'b1});
    pix_ready = 1'b0;
    @(posedge clk); #1;
    check("R5 stalled load", {1'b0, pix_data}, 9'd11);
    check("R7 ready low when stalled", {8'd0, win_ready}, 9'd0);
    offer({8'd10, 8'd12, 8'd14, 8'd12, 8'd40, 8'd12, 1'b0});
    repeat (2) @(posedge clk); #1;
    check("R7 data held", {1'b0, pix_data}, 9'd11);
    check("R7 flag held", {8'd0, pix_noise}, 9'd1);
    check("R7 valid held", {8'd0, pix_valid}, 9'd1);
    @(negedge clk);
    pix_ready = 1'b1;
    #1;
    check("R6 ready when draining", {8'd0, win_ready}, 9'd1);
    @(posedge clk); #1;
    check("R6 pass-through after drain", {1'b0, pix_data}, 9'd12);
    check("R4 flag after drain", {8'd0, pix_noise}, 9'd0);
    @(negedge clk);
    win_valid = 1'b0;

    // reset mid-stream
    offer({8'd0, 8'd255, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1});
    @(posedge clk); #1;
    @(negedge clk);
    win_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8 valid cleared", {8'd0, pix_valid}, 9'd0);
    check("R8 flag cleared", {8'd0, pix_noise}, 9'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule